// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block keeps the 32-bit program counter of a single-cycle processor and returns the instruction word stored at that counter. The word comes from a small instruction memory inside the block. The memory is filled through a simple write port, normally while reset is held. Every clock edge moves the counter to one of three next addresses: the following word, a branch target relative to the following word, or an absolute jump target. The choice depends on the branch control, the ALU zero flag and the jump control that arrive from decode and execute logic outside this block.

The next-address choice is an enumerated selector with three named values.

- `SRC_SEQ` is the fall-through value. It is used whenever neither of the other two applies.
- `SRC_BRANCH` is selected when the branch control and the zero flag are both high and the jump control is low.
- `SRC_JUMP` is selected whenever the jump control is high, whatever the branch control and zero flag are.

The selector is worked out again in every cycle from the current inputs. It holds no history, so any value can follow any other. The program-counter register is the only state in the counter path. The memory array is the only other storage, and both update on the same rising edge.

Top module: `fetch_pc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0 on that edge. Reset takes priority over jumps, branches and sequential stepping.
- R2: `instr` always equals the memory word whose index is `pc[9:2]`, within the same cycle and with no register in between.
- R3: When `jmp` is low and `br_sel` and `alu_zero` are not both high, `pc` advances by 4 at the edge.
- R4: When `jmp` is low and both `br_sel` and `alu_zero` are high, the next `pc` is `pc + 4 + (imm16 sign-extended to 32 bits, shifted left by 2)`.
- R5: If exactly one of `br_sel` and `alu_zero` is high, the branch is not taken and `pc` advances by 4.
- R6: A negative `imm16` (bit 15 set) moves the branch target backwards. For example, `imm16 = 16'hFFFF` gives a next `pc` equal to the current `pc`.
- R7: When `jmp` is high, the next `pc` is `{pc[31:28], jtarget[25:0], 2'b00}`.
- R8: When `jmp` is high at the same time as `br_sel` and `alu_zero`, the jump target is taken.
- R9: A write with `mem_we` high stores `mem_wdata` at word index `mem_waddr` on the edge. Within the write cycle, `instr` still shows the old word, and the new word becomes visible after the edge.
- R10: The memory holds 256 words, and address bits above bit 9 are ignored. A `pc` of `0x400 + 4*k` fetches the same word as `4*k`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| br_sel | input | 1 | Branch control from decode |
| alu_zero | input | 1 | Zero flag from the ALU |
| jmp | input | 1 | Jump control from decode |
| imm16 | input | 16 | Branch word offset field |
| jtarget | input | 26 | Jump target field |
| mem_we | input | 1 | Instruction memory write enable |
| mem_waddr | input | 8 | Word index to write |
| mem_wdata | input | 32 | Word to write |
| pc | output | 32 | Current program counter |
| instr | output | 32 | Instruction word at the current program counter |

## Verification
A wrong next-address selection or a wrong offset shows on `pc` right after the next rising edge. A wrong index into the memory corrupts `instr` within the same cycle. The bench compares both outputs against a behavioural model in every cycle. It checks `instr` before each edge and `pc` after each edge, so a fault is reported in the cycle where it first appears. Directed cases cover backward branches, the two half-enabled branch cases, jumps that collide with a taken branch, address aliasing, and a write to the word currently being fetched. A long run with random control inputs then mixes all of these.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2
    } pc_src_e;

endpackage

// File: rtl/fetch_imem.sv
module fetch_imem #(
    parameter int XLEN  = 32,
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [XLEN-1:0]  wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [XLEN-1:0]  rdata
);

    logic [XLEN-1:0] words_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            words_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = words_q[raddr];
    end

endmodule

// File: rtl/npc_select.sv
module npc_select
    import fetch_pkg::*;
(
    input  logic    br_sel,
    input  logic    alu_zero,
    input  logic    jmp,
    output pc_src_e src
);

    logic take_branch;

    always_comb begin
        take_branch = br_sel & alu_zero;
        if (jmp) begin
            src = SRC_JUMP;
        end else if (take_branch) begin
            src = SRC_BRANCH;
        end else begin
            src = SRC_SEQ;
        end
    end

endmodule

// File: rtl/npc_calc.sv
module npc_calc
    import fetch_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int TGT_W = 26,
    localparam int HI_W  = XLEN - TGT_W - 2,
    localparam int SEXT_W = XLEN - IMM_W - 2
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    input  logic [TGT_W-1:0] tgt,
    input  pc_src_e          src,
    output logic [XLEN-1:0]  npc
);

    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] br_off;
    logic [XLEN-1:0] br_addr;
    logic [XLEN-1:0] jmp_addr;

    always_comb begin
        seq_addr = pc + XLEN'(4);
        br_off   = {{SEXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        br_addr  = seq_addr + br_off;
        jmp_addr = {pc[XLEN-1 -: HI_W], tgt, 2'b00};
        unique case (src)
            SRC_SEQ:    npc = seq_addr;
            SRC_BRANCH: npc = br_addr;
            SRC_JUMP:   npc = jmp_addr;
            default:    npc = seq_addr;
        endcase
    end

endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] npc,
    output logic [XLEN-1:0] pc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= npc;
        end
    end

    // R1: reset forces the counter to zero on the following edge
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> (pc == '0));

endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import fetch_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int IMEM_WORDS = 256,
    parameter int IMM_W      = 16,
    parameter int TGT_W      = 26,
    localparam int IDX_W     = $clog2(IMEM_WORDS),
    localparam int SEXT_W    = XLEN - IMM_W - 2,
    localparam int HI_W      = XLEN - TGT_W - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br_sel,
    input  logic             alu_zero,
    input  logic             jmp,
    input  logic [IMM_W-1:0] imm16,
    input  logic [TGT_W-1:0] jtarget,
    input  logic             mem_we,
    input  logic [IDX_W-1:0] mem_waddr,
    input  logic [XLEN-1:0]  mem_wdata,
    output logic [XLEN-1:0]  pc,
    output logic [XLEN-1:0]  instr
);

    pc_src_e         src;
    logic [XLEN-1:0] npc;

    npc_select u_sel (
        .br_sel   (br_sel),
        .alu_zero (alu_zero),
        .jmp      (jmp),
        .src      (src)
    );

    npc_calc #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W),
        .TGT_W (TGT_W)
    ) u_calc (
        .pc  (pc),
        .imm (imm16),
        .tgt (jtarget),
        .src (src),
        .npc (npc)
    );

    pc_reg #(
        .XLEN (XLEN)
    ) u_pc (
        .clk (clk),
        .rst (rst),
        .npc (npc),
        .pc  (pc)
    );

    fetch_imem #(
        .XLEN  (XLEN),
        .WORDS (IMEM_WORDS)
    ) u_imem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (pc[IDX_W+1:2]),
        .rdata (instr)
    );

    // R3 and R5: without a jump or a fully enabled branch, the counter steps by one word
    a_r3_sequential: assert property (@(posedge clk) disable iff (rst)
        (!jmp && !(br_sel && alu_zero)) |=> (pc == $past(pc) + XLEN'(4)));

    // R4 and R6: a taken branch adds the scaled, sign-extended offset to the next address
    a_r4_branch_taken: assert property (@(posedge clk) disable iff (rst)
        (!jmp && br_sel && alu_zero) |=>
        (pc == $past(pc) + XLEN'(4) +
               {{SEXT_W{$past(imm16[IMM_W-1])}}, $past(imm16), 2'b00}));

    // R7 and R8: a jump keeps the upper bits and splices in the target
    a_r7_jump_splice: assert property (@(posedge clk) disable iff (rst)
        jmp |=> (pc[TGT_W+1:0] == {$past(jtarget), 2'b00}) &&
                (pc[XLEN-1 -: HI_W] == $past(pc[XLEN-1 -: HI_W])));

    // R2: the counter always stays word aligned, so the fetch index is exact
    a_r2_word_aligned: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pc[1:0] == 2'b00));

endmodule

// File: tb/test_fetch_pc_unit.sv
module test_fetch_pc_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        br_sel, alu_zero, jmp;
    logic [15:0] imm16;
    logic [25:0] jtarget;
    logic        mem_we;
    logic [7:0]  mem_waddr;
    logic [31:0] mem_wdata;
    logic [31:0] pc, instr;

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [31:0] m_pc;
    logic [31:0] m_mem [256];
    bit          instr_valid = 0;

    always #5 clk = ~clk;

    fetch_pc_unit i_fetch_pc_unit (
        .clk(clk), .rst(rst), .br_sel(br_sel), .alu_zero(alu_zero), .jmp(jmp),
        .imm16(imm16), .jtarget(jtarget), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .pc(pc), .instr(instr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, check instr before the edge, pc after it
    task automatic cycle(input bit r, input bit b, input bit z, input bit j,
                         input logic [15:0] im, input logic [25:0] tg,
                         input bit we, input logic [7:0] wa, input logic [31:0] wd,
                         input string tag);
        logic [31:0] nxt;
        logic [31:0] off;
        rst = r; br_sel = b; alu_zero = z; jmp = j; imm16 = im; jtarget = tg;
        mem_we = we; mem_waddr = wa; mem_wdata = wd;
        #1;
        if (instr_valid) check({tag, " R2/R9 instr"}, instr, m_mem[m_pc[9:2]]);
        off = 32'($signed(im)) * 4;
        if (r)            nxt = 32'h0;
        else if (j)       nxt = {m_pc[31:28], tg, 2'b00};
        else if (b && z)  nxt = m_pc + 4 + off;
        else              nxt = m_pc + 4;
        @(posedge clk);
        m_pc = nxt;
        if (we) m_mem[wa] = wd;
        @(negedge clk);
        check({tag, " pc"}, pc, m_pc);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] keep;
        rst = 1; br_sel = 0; alu_zero = 0; jmp = 0; imm16 = 0; jtarget = 0;
        mem_we = 0; mem_waddr = 0; mem_wdata = 0;
        m_pc = 0;
        @(negedge clk);
        // R1/R9: fill memory while reset holds the counter at zero
        for (int i = 0; i < 256; i++) begin
            cycle(1, 1, 1, 1, 16'h7, 26'h33, 1, 8'(i),
                  32'hC0DE_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'(i << 5), "R1 load");
        end
        instr_valid = 1;
        check("R1 reset pc", pc, 32'h0);
        // R3: straight-line stepping
        for (int i = 0; i < 6; i++) cycle(0, 0, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R3 seq");
        // R4: forward branch taken
        cycle(0, 1, 1, 0, 16'd5, 26'h0, 0, 0, 0, "R4 branch fwd");
        // R5: half-enabled branch cases fall through
        cycle(0, 1, 0, 0, 16'd9, 26'h0, 0, 0, 0, "R5 br no zero");
        cycle(0, 0, 1, 0, 16'd9, 26'h0, 0, 0, 0, "R5 zero no br");
        // R6: backward branch, and self-loop with offset -1
        cycle(0, 1, 1, 0, 16'hFFFC, 26'h0, 0, 0, 0, "R6 branch back");
        cycle(0, 1, 1, 0, 16'hFFFF, 26'h0, 0, 0, 0, "R6 self loop");
        // R7: jump
        cycle(0, 0, 0, 1, 16'h0, 26'h40, 0, 0, 0, "R7 jump");
        // R8: jump beats a taken branch
        cycle(0, 1, 1, 1, 16'h20, 26'h12, 0, 0, 0, "R8 jump priority");
        // R10: alias above the memory size
        cycle(0, 0, 0, 1, 16'h0, 26'h103, 0, 0, 0, "R10 alias");
        check("R10 alias instr", instr, m_mem[8'h03]);
        // R9: overwrite the word being fetched while looping on it
        keep = m_mem[m_pc[9:2]];
        cycle(0, 1, 1, 0, 16'hFFFF, 26'h0, 1, m_pc[9:2], 32'hFEED_BEEF, "R9 write");
        check("R9 new word", instr, 32'hFEED_BEEF);
        check("R9 old replaced", (keep != 32'hFEED_BEEF) ? 32'h1 : 32'h0, 32'h1);
        // mixed random run
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            cycle(0, rv[0], rv[1], rv[2] & rv[3], 16'($urandom), 26'($urandom & 32'h3FF),
                  rv[4] & rv[5], 8'($urandom), $urandom, "R3/R4/R7 mix");
        end
        // R1: reset in mid-run overrides a jump
        cycle(1, 1, 1, 1, 16'h5, 26'h99, 0, 0, 0, "R1 reset mid-run");
        check("R1 reset pc zero", pc, 32'h0);
        cycle(0, 0, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R3 after reset");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule